// File: doc/BRIEF.md
# Phase-Staggered Multichannel PWM Generator

This block drives sixteen pulse-width-modulated outputs from one shared 12-bit free-running counter. Every channel has its own 12-bit turn-on and turn-off compare points. Each channel also has two override flags: one forces the output high for the whole period and one forces it low. The active window may cross the end of the count, so a pulse can start late in one period and end early in the next. The effective duty cycle is always (OFF − ON) mod 4096.

Software programs the channels through a byte-wide register port. Each 12-bit point is split into a low byte and a high byte, and the high byte also holds the override flag. A broadcast register group writes the same byte into every channel at once. When the stagger input is asserted, each channel's window is shifted later by its index times one sixteenth of the period. This spreads the rising edges evenly across the period while every duty cycle stays the same.

Compare values, flags and the stagger selection are held in shadow copies. The running outputs pick them up only when the counter rolls over to zero, so an update never produces a partial pulse.

Top module: `stagger_pwm`

## Requirements
- R1: The internal 12-bit count advances by one on every clock on which `cnt_en` is high, wraps from 4095 to 0, and holds its value while `cnt_en` is low.
- R2: Channel n (0..15) occupies byte addresses 4n..4n+3, in this order:
  - ON bits 7:0.
  - ON high: bits 3:0 hold ON[11:8] and bit 4 holds the force-high flag.
  - OFF bits 7:0.
  - OFF high: bits 3:0 hold OFF[11:8] and bit 4 holds the force-low flag.

  Reading any of these addresses returns the last value written, and bits 7:5 of a high byte always read as 0.
- R3: After reset, every channel has the force-low flag set, the force-high flag clear, and ON = OFF = 0. All outputs are low.
- R4: When neither flag is set and ON < OFF, the output is high for counter values ON through OFF−1 and low otherwise.
- R5: When neither flag is set and ON > OFF, the output is high for counter values ON through 4095 and 0 through OFF−1. When ON equals OFF, the output stays low.
- R6: With only the force-high flag set, the output is high for the entire period. With the force-low flag set, the output is low whatever the other flag and compare values hold.
- R7: A write to a high byte replaces both the four value bits and the flag, so writing a new value with bit 4 clear removes an earlier override.
- R8: A write to addresses 64..67 applies the same byte to every channel, with the layout of R2. Reads of 64..67 and of any address above 67 return 0, and writes above 67 change nothing.
- R9: Compare values, flags and the stagger selection reach the outputs only on the clock where the count wraps from 4095 to 0. Until that clock, outputs follow the previous settings.
- R10: When `stagger_en` is high at the wrap, channel n's ON and OFF points are both shifted later by n × 256 counts, modulo 4096. This preserves each channel's duty cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Advances the shared counter by one when high |
| stagger_en | input | 1 | Selects phase-staggered windows (taken at counter wrap) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| pwm_out | output | 16 | One PWM output per channel |

## Verification
A corrupted register byte shows up immediately on `reg_rdata`. A corrupted shadow copy or compare result shows up on `pwm_out` no later than one full period, 4096 enabled counts, after the wrap that loaded it. A counter that skips or stalls a value moves every channel's edges at once, and the bench catches this at the first mismatching edge, because each sweep compares all sixteen outputs against an arithmetic model on every clock. A shadow load at the wrong moment appears as an edge in the period before the wrap. A wrong stagger offset moves one channel's rising edge away from n × 256.

// File: rtl/stagger_pwm_pkg.sv
package stagger_pwm_pkg;

    localparam int unsigned CNT_W    = 12;
    localparam int unsigned LO_W     = 8;
    localparam int unsigned HI_W     = CNT_W - LO_W;
    localparam int unsigned FLAG_BIT = HI_W;

    typedef enum logic [1:0] {
        SEL_ON_LO  = 2'd0,
        SEL_ON_HI  = 2'd1,
        SEL_OFF_LO = 2'd2,
        SEL_OFF_HI = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             full_on;
        logic             full_off;
        logic [CNT_W-1:0] on_cnt;
        logic [CNT_W-1:0] off_cnt;
    } chan_cfg_t;

    localparam chan_cfg_t CFG_RESET = '{full_on: 1'b0, full_off: 1'b1,
                                        on_cnt: '0, off_cnt: '0};

    // Merge one written byte into a channel configuration.
    function automatic chan_cfg_t cfg_write(chan_cfg_t c, reg_sel_e s, logic [7:0] d);
        chan_cfg_t r;
        r = c;
        case (s)
            SEL_ON_LO:  r.on_cnt[LO_W-1:0] = d;
            SEL_ON_HI: begin
                r.on_cnt[CNT_W-1:LO_W] = d[HI_W-1:0];
                r.full_on              = d[FLAG_BIT];
            end
            SEL_OFF_LO: r.off_cnt[LO_W-1:0] = d;
            SEL_OFF_HI: begin
                r.off_cnt[CNT_W-1:LO_W] = d[HI_W-1:0];
                r.full_off              = d[FLAG_BIT];
            end
        endcase
        return r;
    endfunction

    // Produce the readback byte of one channel register.
    function automatic logic [7:0] cfg_read(chan_cfg_t c, reg_sel_e s);
        logic [7:0] r;
        r = '0;
        case (s)
            SEL_ON_LO:  r = c.on_cnt[LO_W-1:0];
            SEL_ON_HI: begin
                r[HI_W-1:0] = c.on_cnt[CNT_W-1:LO_W];
                r[FLAG_BIT] = c.full_on;
            end
            SEL_OFF_LO: r = c.off_cnt[LO_W-1:0];
            SEL_OFF_HI: begin
                r[HI_W-1:0] = c.off_cnt[CNT_W-1:LO_W];
                r[FLAG_BIT] = c.full_off;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pwm_counter.sv
module pwm_counter
    import stagger_pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_state_t;

    ctr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt  = st_q.cnt;
    // R1: rollover strobe, also the shadow-load moment for R9
    assign wrap = en && (st_q.cnt == '1);

endmodule

// File: rtl/pwm_regfile.sv
module pwm_regfile
    import stagger_pwm_pkg::*;
#(
    parameter int unsigned NUM_CH = 16,
    parameter int unsigned ADDR_W = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [7:0]             wdata,
    output logic [7:0]             rdata,
    output chan_cfg_t [NUM_CH-1:0] prog
);

    localparam int unsigned CH_W = ADDR_W - 2;

    typedef struct packed {
        chan_cfg_t [NUM_CH-1:0] cfg;
    } rf_state_t;

    rf_state_t        st_d, st_q;
    logic [CH_W-1:0]  ch_sel;
    reg_sel_e         byte_sel;
    logic             bcast_hit;

    assign ch_sel    = addr[ADDR_W-1:2];
    assign byte_sel  = reg_sel_e'(addr[1:0]);
    // R8: the group just past the last channel writes every channel
    assign bcast_hit = (ch_sel == CH_W'(NUM_CH));

    always_comb begin
        st_d  = st_q;
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (we && (bcast_hit || ch_sel == CH_W'(i))) begin
                st_d.cfg[i] = cfg_write(st_q.cfg[i], byte_sel, wdata);
            end
            if (ch_sel == CH_W'(i)) begin
                rdata = cfg_read(st_q.cfg[i], byte_sel);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cfg <= {NUM_CH{CFG_RESET}};
        end else begin
            st_q <= st_d;
        end
    end

    assign prog = st_q.cfg;

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import stagger_pwm_pkg::*;
#(
    parameter int unsigned NUM_CH = 16,
    parameter int unsigned CH_IDX = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             stagger_en,
    input  chan_cfg_t        prog,
    input  logic [CNT_W-1:0] cnt,
    output logic             out
);

    localparam int unsigned      STEP  = (1 << CNT_W) / NUM_CH;
    localparam logic [CNT_W-1:0] SHIFT = CNT_W'(STEP * CH_IDX);

    typedef struct packed {
        chan_cfg_t act;
        logic      stag;
    } chan_state_t;

    chan_state_t      st_d, st_q;
    logic [CNT_W-1:0] shift;
    logic [CNT_W-1:0] on_e;
    logic [CNT_W-1:0] off_e;
    logic             win;

    // R9: shadow copy refreshed only at counter rollover
    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.act  = prog;
            st_d.stag = stagger_en;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.act  <= CFG_RESET;
            st_q.stag <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        // R10: both edges move by the same amount, duty unchanged
        shift = st_q.stag ? SHIFT : '0;
        on_e  = st_q.act.on_cnt + shift;
        off_e = st_q.act.off_cnt + shift;
        if (on_e < off_e) begin
            win = (cnt >= on_e) && (cnt < off_e);          // R4
        end else if (on_e > off_e) begin
            win = (cnt >= on_e) || (cnt < off_e);          // R5 wrapped
        end else begin
            win = 1'b0;                                     // R5 empty
        end
        // R6: force-low beats force-high beats the window
        out = !st_q.act.full_off && (st_q.act.full_on || win);
    end

endmodule

// File: rtl/stagger_pwm.sv
module stagger_pwm
    import stagger_pwm_pkg::*;
#(
    parameter  int unsigned NUM_CH = 16,
    localparam int unsigned ADDR_W = $clog2(4 * (NUM_CH + 1))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic              stagger_en,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    logic [CNT_W-1:0]       cnt;
    logic                   wrap;
    chan_cfg_t [NUM_CH-1:0] prog;

    pwm_counter u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (cnt_en),
        .cnt   (cnt),
        .wrap  (wrap)
    );

    pwm_regfile #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_regfile (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .prog  (prog)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        pwm_chan #(
            .NUM_CH (NUM_CH),
            .CH_IDX (g)
        ) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (wrap),
            .stagger_en (stagger_en),
            .prog       (prog[g]),
            .cnt        (cnt),
            .out        (pwm_out[g])
        );
    end

endmodule

// File: rtl/stagger_pwm_chk.sv
module stagger_pwm_chk
    import stagger_pwm_pkg::*;
#(
    parameter int unsigned NUM_CH = 16,
    parameter int unsigned ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cnt_en,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [7:0]        reg_rdata,
    input logic [NUM_CH-1:0] pwm_out,
    input logic [CNT_W-1:0]  cnt,
    input logic              wrap
);

    logic seen_wrap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_wrap_q <= 1'b0;
        end else if (wrap) begin
            seen_wrap_q <= 1'b1;
        end
    end

    p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_en |=> (cnt == CNT_W'($past(cnt) + CNT_W'(1))));

    p_count_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> $stable(cnt));

    p_hi_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr[0] |-> (reg_rdata[7:FLAG_BIT+1] == '0));

    p_low_until_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_wrap_q |-> (pwm_out == '0));

    p_bcast_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(reg_addr[ADDR_W-1:2]) >= NUM_CH) |-> (reg_rdata == 8'h00));

    p_frozen_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> $stable(pwm_out));

endmodule

bind stagger_pwm stagger_pwm_chk #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_en    (cnt_en),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .pwm_out   (pwm_out),
    .cnt       (cnt),
    .wrap      (wrap)
);

// File: tb/test_stagger_pwm.sv
`timescale 1ns/1ps
module test_stagger_pwm;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cnt_en;
    logic        stagger_en;
    logic        reg_we;
    logic [6:0]  reg_addr;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;
    logic [15:0] pwm_out;

    int checks = 0;
    int errors = 0;

    // bench model: programmed and active settings
    int m_cnt;
    int p_on[16], p_off[16], a_on[16], a_off[16];
    bit p_fon[16], p_foff[16], a_fon[16], a_foff[16];
    bit a_stag;

    always #10 clk = ~clk;

    stagger_pwm i_stagger_pwm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_en     (cnt_en),
        .stagger_en (stagger_en),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .pwm_out    (pwm_out)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit exp_bit(input int ch, input int c);
        int sh, on, off;
        sh  = a_stag ? ch * 256 : 0;
        on  = (a_on[ch] + sh) % 4096;
        off = (a_off[ch] + sh) % 4096;
        if (a_foff[ch]) return 1'b0;
        if (a_fon[ch])  return 1'b1;
        if (on < off)   return (c >= on) && (c < off);
        if (on > off)   return (c >= on) || (c < off);
        return 1'b0;
    endfunction

    function automatic logic [15:0] exp_vec();
        logic [15:0] v;
        for (int ch = 0; ch < 16; ch++) v[ch] = exp_bit(ch, m_cnt);
        return v;
    endfunction

    function automatic void apply_one(input int ch, input int sel, input int d);
        case (sel)
            0: p_on[ch]  = (p_on[ch] & 'hF00) | (d & 'hFF);
            1: begin p_on[ch] = (p_on[ch] & 'hFF) | ((d & 'hF) << 8); p_fon[ch] = bit'((d >> 4) & 1); end
            2: p_off[ch] = (p_off[ch] & 'hF00) | (d & 'hFF);
            default: begin p_off[ch] = (p_off[ch] & 'hFF) | ((d & 'hF) << 8); p_foff[ch] = bit'((d >> 4) & 1); end
        endcase
    endfunction

    function automatic int rd_exp(input int ch, input int sel);
        case (sel)
            0: return p_on[ch] & 'hFF;
            1: return ((p_on[ch] >> 8) & 'hF) | (int'(p_fon[ch]) << 4);
            2: return p_off[ch] & 'hFF;
            default: return ((p_off[ch] >> 8) & 'hF) | (int'(p_foff[ch]) << 4);
        endcase
    endfunction

    task automatic wr(input int addr, input int data);
        int ch, sel;
        @(negedge clk);
        reg_addr  = 7'(addr);
        reg_wdata = 8'(data);
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
        ch  = addr >> 2;
        sel = addr & 3;
        if (ch < 16) apply_one(ch, sel, data);
        else if (ch == 16) for (int k = 0; k < 16; k++) apply_one(k, sel, data);
    endtask

    task automatic rd_check(input int addr, input int exp, input string req);
        @(negedge clk);
        reg_addr = 7'(addr);
        #2;
        check(reg_rdata == 8'(exp), req, $sformatf("read addr %0d", addr),
              int'(reg_rdata), exp);
    endtask

    task automatic prog_chan(input int ch, input int on, input int off,
                             input bit fon, input bit foff);
        wr(ch * 4 + 0, on & 'hFF);
        wr(ch * 4 + 1, ((on >> 8) & 'hF) | (int'(fon) << 4));
        wr(ch * 4 + 2, off & 'hFF);
        wr(ch * 4 + 3, ((off >> 8) & 'hF) | (int'(foff) << 4));
    endtask

    // Compare all outputs every clock; one check per run.
    task automatic run(input int n, input bit gaps, input string req, input string what);
        bit ok;
        int act, ex, at;
        bit en;
        logic [15:0] e;
        ok = 1'b1; act = 0; ex = 0; at = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            e = exp_vec();
            if (ok && pwm_out !== e) begin
                ok = 1'b0; act = int'(pwm_out); ex = int'(e); at = m_cnt;
            end
            en = gaps ? (i % 5 != 4) : 1'b1;
            cnt_en = en;
            @(posedge clk);
            if (en) begin
                if (m_cnt == 4095) begin
                    m_cnt = 0;
                    a_on = p_on; a_off = p_off; a_fon = p_fon; a_foff = p_foff;
                    a_stag = stagger_en;
                end else begin
                    m_cnt++;
                end
            end
        end
        @(negedge clk);
        cnt_en = 1'b0;
        check(ok, req, $sformatf("%s (first mismatch at count %0d)", what, at), act, ex);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cnt_en = 1'b0; stagger_en = 1'b0;
        reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        m_cnt = 0; a_stag = 1'b0;
        for (int k = 0; k < 16; k++) begin
            p_on[k] = 0; p_off[k] = 0; p_fon[k] = 1'b0; p_foff[k] = 1'b1;
        end
        a_on = p_on; a_off = p_off; a_fon = p_fon; a_foff = p_foff;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R3: reset state
        #2;
        check(pwm_out == 16'h0, "R3", "outputs after reset", int'(pwm_out), 0);
        rd_check(3, 'h10, "R3");
        rd_check(15 * 4 + 3, 'h10, "R3");
        rd_check(7 * 4 + 1, 'h00, "R3");
        run(4096, 1'b0, "R3", "all low first period");

        // R2: upper bits of a high byte read as zero
        wr(15 * 4 + 3, 'hF7);
        rd_check(15 * 4 + 3, 'h17, "R2");

        // program a mix of windows and overrides
        for (int ch = 0; ch < 12; ch++)
            prog_chan(ch, (ch * 331 + 17) % 4096, (ch * 577 + 900) % 4096, 1'b0, 1'b0);
        prog_chan(1, 0, 4095, 1'b0, 1'b0);
        prog_chan(2, 4095, 0, 1'b0, 1'b0);
        prog_chan(3, 4095, 1, 1'b0, 1'b0);
        prog_chan(12, 500, 500, 1'b0, 1'b0);
        prog_chan(13, 100, 200, 1'b1, 1'b1);
        prog_chan(14, 700, 300, 1'b1, 1'b0);
        prog_chan(15, 40, 3000, 1'b0, 1'b1);
        for (int ch = 0; ch < 16; ch++)
            for (int s = 0; s < 4; s++)
                rd_check(ch * 4 + s, rd_exp(ch, s), "R2");

        // R9: nothing visible until the wrap, then R4/R5/R6 windows
        run(4096, 1'b0, "R9", "old settings held until wrap");
        run(5120, 1'b1, "R1 R4 R5 R6", "windows with counter pauses");

        // R9: mid-period writes take effect only at the next wrap
        run(1000, 1'b0, "R9", "first part of period");
        wr(0, 'h99);
        wr(13 * 4 + 3, 'h05);
        run(3096, 1'b0, "R9", "rest of period after write");
        run(4096, 1'b0, "R6 R9", "new values after wrap");

        // R7: high-byte write clears the override
        wr(14 * 4 + 1, 'h02);
        rd_check(14 * 4 + 1, 'h02, "R7");
        run(4096, 1'b0, "R7", "period before load");
        run(4096, 1'b0, "R7", "override removed");

        // R8: broadcast writes, unreadable group, unmapped space
        wr(64, 'h40); wr(65, 'h01); wr(66, 'h80); wr(67, 'h02);
        for (int ch = 0; ch < 16; ch++) begin
            rd_check(ch * 4 + 0, 'h40, "R8");
            rd_check(ch * 4 + 3, 'h02, "R8");
        end
        rd_check(64, 0, "R8");
        rd_check(67, 0, "R8");
        wr(100, 'hFF);
        rd_check(100, 0, "R8");
        rd_check(3 * 4 + 3, 'h02, "R8");
        run(4096, 1'b0, "R8", "broadcast pending");
        run(4096, 1'b0, "R8", "broadcast active");

        // R10: staggered windows
        @(negedge clk);
        stagger_en = 1'b1;
        wr(64, 0); wr(65, 0); wr(66, 'h00); wr(67, 'h03);
        run(4096, 1'b0, "R10", "transition period");
        run(4096, 1'b0, "R10", "staggered duty 0x300");
        wr(66, 'h80); wr(67, 'h0E);
        run(4096, 1'b0, "R10", "transition period 2");
        run(4096, 1'b0, "R10", "staggered wrapped duty 0xE80");
        @(negedge clk);
        stagger_en = 1'b0;
        run(4096, 1'b0, "R10", "stagger dropping");
        run(4096, 1'b0, "R10", "stagger off");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule